// File: doc/BRIEF.md
# Voltage-Slope Fault Trip Detector

This block watches a stream of low-pass-filtered line-voltage samples and decides when a DC line fault has occurred. Each time a new sample is marked valid, the block subtracts the previously accepted sample from it. The result is the voltage change over one sample period, nominally 20 µs. If that change is a drop at least as steep as a programmable negative slope limit, the block raises a latched trip toward the breaker interface. Filtering happens upstream, so the detector itself has no noise suppression.

The slope limit is a signed code on the same scale as the samples. As an example, with 10 V per code, the usual settings of 6, 10, 15, 20 and 40 kV per period are -600, -1000, -1500, -2000 and -4000. An operator or another protection function can also force the trip through a manual request. Once set, the trip stays high until a clear pulse arrives. A one-cycle event strobe marks the moment the trip first rises, so that a capture unit can freeze its record at that point.

Top module: `vslope_trip`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, `trip_o` and `trip_evt_o` are 0 and no previous sample is held.
- R2: The first valid sample after reset is only stored as the previous sample and never causes a trip, whatever its value.
- R3: The change is computed as current minus previous in SAMPLE_W+1 bits. A full-scale drop (most positive code to most negative code) therefore counts as a drop and a full-scale rise counts as a rise, with no wrap-around.
- R4: A valid sample that has a stored predecessor causes a trip when the change is negative and less than or equal to `slope_limit`, both read as two's complement. A change exactly equal to the limit trips. A change one code less steep does not. A rise or a zero change never trips, even when the limit is zero or positive.
- R5: While `smp_valid` is 0, `smp_data` is ignored: it is neither compared nor stored as the previous sample.
- R6: `trip_o` is registered. It rises on the clock edge that ends the cycle holding the qualifying sample and stays 1 until a clear.
- R7: `force_trip` = 1 in a cycle sets `trip_o` at the next clock edge.
- R8: `trip_clear` = 1 drops `trip_o` at the next edge. If a slope trip or a manual trip occurs in the same cycle, the trip wins and `trip_o` stays or becomes 1.
- R9: `trip_evt_o` is 1 for exactly the one cycle in which `trip_o` has just gone from 0 to 1, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Marks `smp_data` as a new sample this cycle |
| smp_data | input | SAMPLE_W | Filtered voltage sample, two's complement |
| slope_limit | input | SAMPLE_W+1 | Trip limit on the per-sample change, two's complement (negative in normal use) |
| force_trip | input | 1 | Manual trip request |
| trip_clear | input | 1 | Clears the latched trip |
| trip_o | output | 1 | Latched trip toward the breaker |
| trip_evt_o | output | 1 | One-cycle strobe when the trip first rises |

## Verification
The bench builds the block with SAMPLE_W = 12. At that width the most positive and most negative codes can be driven directly, and a steepest-setting limit of -4000 fits in the 13-bit limit port. This makes the full-scale drop of -4095 reachable: it trips only if the extra difference bit is present. It also makes the full-scale rise of +4095 reachable: it would look like -1 if the change wrapped, and it is tested against a zero limit. The limit is also stepped across several settings to probe the inclusive edge at exactly the limit and one code inside it.

// File: rtl/vslope_pkg.sv
package vslope_pkg;

    // Registered state of the trip latch
    typedef struct packed {
        logic trip;
        logic evt;
    } trip_state_t;

endpackage

// File: rtl/vslope_diff.sv
module vslope_diff #(
    parameter int SAMPLE_W = 16,
    localparam int DW = SAMPLE_W + 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       smp_valid,
    input  logic signed [SAMPLE_W-1:0] smp_data,
    output logic signed [DW-1:0]       delta_o,
    output logic                       primed_o
);

    typedef struct packed {
        logic signed [SAMPLE_W-1:0] prev;
        logic                       primed;
    } diff_state_t;

    diff_state_t state_d, state_q;
    logic signed [DW-1:0] cur_ext, prev_ext;

    always_comb begin
        state_d = state_q;
        if (smp_valid) begin
            state_d.prev   = smp_data;
            state_d.primed = 1'b1;
        end
        // sign-extend both operands by one bit so the difference cannot wrap (R3)
        cur_ext  = $signed({smp_data[SAMPLE_W-1], smp_data});
        prev_ext = $signed({state_q.prev[SAMPLE_W-1], state_q.prev});
        delta_o  = cur_ext - prev_ext;
        primed_o = state_q.primed;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // R5: a cycle without a valid strobe leaves the stored sample alone
    a_r5_prev_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> $stable(state_q.prev));

    // R2: once a valid sample is accepted the stage is primed
    a_r2_primes: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> primed_o);

endmodule

// File: rtl/vslope_cmp.sv
module vslope_cmp #(
    parameter int SAMPLE_W = 16,
    localparam int DW = SAMPLE_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_valid,
    input  logic                 primed,
    input  logic signed [DW-1:0] delta,
    input  logic signed [DW-1:0] slope_limit,
    output logic                 hit_o
);

    logic is_drop;
    logic at_limit;

    always_comb begin
        is_drop  = delta < 0;
        at_limit = delta <= slope_limit;   // inclusive comparison (R4)
        hit_o    = smp_valid && primed && is_drop && at_limit;
    end

    // R4: a hit is only ever a voltage collapse
    a_r4_only_drop: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> (delta < 0));

    // R2: nothing is compared before a previous sample exists
    a_r2_no_first_hit: assert property (@(posedge clk) disable iff (!rst_n)
        !primed |-> !hit_o);

endmodule

// File: rtl/vslope_latch.sv
module vslope_latch
    import vslope_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic force_trip,
    input  logic trip_clear,
    output logic trip_o,
    output logic trip_evt_o
);

    trip_state_t state_d, state_q;
    logic set_req;

    always_comb begin
        set_req       = hit || force_trip;
        state_d.trip  = set_req || (state_q.trip && !trip_clear);  // set wins (R8)
        state_d.evt   = state_d.trip && !state_q.trip;
        trip_o        = state_q.trip;
        trip_evt_o    = state_q.evt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // R6: the trip holds until a clear
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (trip_o && !trip_clear) |=> trip_o);

    // R7: a manual request always yields a trip
    a_r7_force: assert property (@(posedge clk) disable iff (!rst_n)
        force_trip |=> trip_o);

    // R8: a lone clear drops the trip
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (trip_clear && !hit && !force_trip) |=> !trip_o);

    // R9: the strobe coincides with a rising trip
    a_r9_evt_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trip_o) |-> trip_evt_o);

    a_r9_evt_only_rise: assert property (@(posedge clk) disable iff (!rst_n)
        trip_evt_o |-> (trip_o && !$past(trip_o)));

endmodule

// File: rtl/vslope_trip.sv
module vslope_trip #(
    parameter int SAMPLE_W = 16,
    localparam int DW = SAMPLE_W + 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       smp_valid,
    input  logic signed [SAMPLE_W-1:0] smp_data,
    input  logic signed [DW-1:0]       slope_limit,
    input  logic                       force_trip,
    input  logic                       trip_clear,
    output logic                       trip_o,
    output logic                       trip_evt_o
);

    logic signed [DW-1:0] delta;
    logic                 primed;
    logic                 hit;

    vslope_diff #(.SAMPLE_W(SAMPLE_W)) u_diff (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .delta_o   (delta),
        .primed_o  (primed)
    );

    vslope_cmp #(.SAMPLE_W(SAMPLE_W)) u_cmp (
        .clk         (clk),
        .rst_n       (rst_n),
        .smp_valid   (smp_valid),
        .primed      (primed),
        .delta       (delta),
        .slope_limit (slope_limit),
        .hit_o       (hit)
    );

    vslope_latch u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit        (hit),
        .force_trip (force_trip),
        .trip_clear (trip_clear),
        .trip_o     (trip_o),
        .trip_evt_o (trip_evt_o)
    );

    // R1: first cycle out of reset is quiet
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!trip_o && !trip_evt_o));

    // R2: the first accepted sample cannot trip
    a_r2_first_sample: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !primed && !force_trip && !trip_o) |=> !trip_o);

endmodule

// File: tb/vslope_trip_bench.sv
module vslope_trip_bench;

    localparam int CLK_PERIOD = 10;
    localparam int SW = 12;
    localparam int DW = SW + 1;

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic                 smp_valid;
    logic signed [SW-1:0] smp_data;
    logic signed [DW-1:0] slope_limit;
    logic                 force_trip;
    logic                 trip_clear;
    logic                 trip_o;
    logic                 trip_evt_o;

    vslope_trip #(.SAMPLE_W(SW)) u_vslope_trip (
        .clk         (clk),
        .rst_n       (rst_n),
        .smp_valid   (smp_valid),
        .smp_data    (smp_data),
        .slope_limit (slope_limit),
        .force_trip  (force_trip),
        .trip_clear  (trip_clear),
        .trip_o      (trip_o),
        .trip_evt_o  (trip_evt_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        bit    trip;
        bit    evt;
        string tag;
    } exp_item_t;

    exp_item_t exp_q[$];
    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    // bench reference state
    bit m_trip;
    bit m_primed;
    int m_prev;

    task automatic check(input string tag, input bit got, input bit want, input string what);
        checks++;
        if (got !== want) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b", tag, what, got, want);
        end
    endtask

    // driver: drive one cycle of stimulus and push the expected outcome
    task automatic step(input bit v, input int data, input bit frc, input bit clr, input string tag);
        exp_item_t it;
        bit hit;
        bit nxt;
        int d;
        @(negedge clk);
        smp_valid  = v;
        smp_data   = SW'(data);
        force_trip = frc;
        trip_clear = clr;
        d   = data - m_prev;
        hit = v && m_primed && (d < 0) && (d <= int'(slope_limit));
        nxt = hit || frc || (m_trip && !clr);
        it.trip = nxt;
        it.evt  = nxt && !m_trip;
        it.tag  = tag;
        exp_q.push_back(it);
        m_trip = nxt;
        if (v) begin
            m_prev   = data;
            m_primed = 1'b1;
        end
    endtask

    // monitor: compare just after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_item_t it;
                it = exp_q.pop_front();
                check(it.tag, trip_o, it.trip, "trip_o");
                check(it.tag, trip_evt_o, it.evt, "trip_evt_o");
            end
        end
    end

    initial begin
        rst_n = 1'b0; smp_valid = 1'b0; smp_data = '0;
        slope_limit = -13'sd600; force_trip = 1'b0; trip_clear = 1'b0;
        m_trip = 1'b0; m_primed = 1'b0; m_prev = 0;
        repeat (3) @(negedge clk);
        check("R1", trip_o, 1'b0, "trip_o in reset");
        check("R1", trip_evt_o, 1'b0, "trip_evt_o in reset");
        rst_n = 1'b1;

        // R2: steep first sample must not trip
        step(1, -2000, 0, 0, "R2");
        // R4: limit -600, drop 599 -> none, drop 600 -> trip
        step(1, -2599, 0, 0, "R4_short");
        step(1, -3199, 0, 0, "R4_equal");
        step(0, 0, 0, 0, "R6_hold");
        step(1, -3800, 0, 0, "R9_no_retrigger");
        step(0, 0, 0, 1, "R8_clear");
        // R5: unqualified sample ignored; next compare uses -3800
        step(0, 2000, 0, 0, "R5_ignored");
        step(1, -3800, 0, 0, "R5_prev_kept");
        step(1, 0, 0, 0, "R4_rise");
        step(1, 2047, 0, 0, "R4_rise2");
        // R3: full-scale drop at the steepest setting
        slope_limit = -13'sd4000;
        step(1, -2048, 0, 0, "R3_full_drop");
        step(0, 0, 0, 1, "R8_clear2");
        // R3/R4: full-scale rise with zero limit
        slope_limit = 13'sd0;
        step(1, 2047, 0, 0, "R3_full_rise");
        step(1, 2047, 0, 0, "R4_zero_change");
        // R7: manual trip
        step(0, 0, 1, 0, "R7_force");
        step(0, 0, 0, 0, "R7_hold");
        // R8: clear with force at the same time keeps trip
        step(0, 0, 1, 1, "R8_force_wins");
        step(0, 0, 0, 1, "R8_clear3");
        // R8: clear with slope hit at the same time sets trip
        slope_limit = -13'sd1000;
        step(1, 1000, 0, 1, "R8_hit_wins");
        step(0, 0, 0, 1, "R8_clear4");
        // R4: other settings, exact edge
        slope_limit = -13'sd1500;
        step(1, -499, 0, 0, "R4_1499");
        step(1, -1999, 0, 0, "R4_1500");
        step(0, 0, 0, 0, "R9_idle");
        step(0, 0, 0, 0, "R6_idle");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule